// File: doc/BRIEF.md
# Audio Control Byte Receiver (I2C Write Slave)

This block is a write-only I2C-compatible target that sets the control state of an audio subsystem. The bus clock and data lines arrive as plain inputs, are oversampled on the system clock, and the block answers by pulling the data line low through an open-drain enable during acknowledge slots. One input pin chooses which of two device addresses the block answers to.

No sub-address byte is used. Each data byte carries its own destination in its top bits: a two-bit prefix selects the operating-mode register or the spatial-effect/input-routing register, and a three-bit prefix selects one of three 5-bit volume codes. A host may send several such bytes after one address. Each byte is decoded and acknowledged separately, and a register changes only once its byte has been acknowledged.

Top module: `audio_ctl_i2c_slave`

## Requirements
- R1: After reset every control output is 0 (mode code 000 = shutdown, capless bit 0, all volumes 0) and the SDA pull-low output is inactive.
- R2: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. Bits are captured on SCL rising edges, most significant bit first.
- R3: The address byte 0xF8 is accepted when addr_sel_i is 0 and 0xFA when it is 1 (bit 1 follows the pin, bit 0 is the write flag 0). On a match, SDA is pulled low across the ninth clock. On any other byte, including a read flag, SDA stays released and all data bytes up to the next START are ignored.
- R4: Every data byte of an accepted transaction is acknowledged by pulling SDA low across its ninth clock.
- R5: A data byte with bits 7:6 = 00 loads the mode register: bit 5 to diff_sel_o, bit 3 to capless_o and bits 2:0 to mode_o. Bit 4 is not stored.
- R6: A data byte with bits 7:6 = 01 loads the effect register: bit 5 to pair2_sel_o, bit 4 to pair1_sel_o, bits 3:2 to fx_level_o (00 low, 01 medium, 10 high, 11 maximum), bit 1 to fx_cfg_o and bit 0 to fx_en_o.
- R7: A data byte with bits 7:5 = 100, 110 or 111 loads bits 4:0 into vol_mono_o, vol_left_o or vol_right_o, in that order.
- R8: A data byte with bits 7:5 = 101 is acknowledged, and every output stays unchanged.
- R9: A register changes only after the SCL falling edge that ends the acknowledge clock of its data byte. A STOP or repeated START in the middle of a byte discards the bits received so far.
- R10: Several data bytes that follow one address are each decoded and acknowledged until STOP.
- R11: The SDA pull-low output never changes while SCL is held high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 8x the SCL rate |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line (raw) |
| sda_i | input | 1 | Bus data line (raw, wired level) |
| addr_sel_i | input | 1 | Device address select |
| sda_pull_o | output | 1 | Drive SDA low when 1 (open-drain enable) |
| mode_o | output | 3 | Output mode code |
| diff_sel_o | output | 1 | Differential stereo input select |
| capless_o | output | 1 | Capacitor-less headphone select |
| pair2_sel_o | output | 1 | Second stereo input pair select |
| pair1_sel_o | output | 1 | First stereo input pair select |
| fx_level_o | output | 2 | Spatial effect strength |
| fx_cfg_o | output | 1 | Spatial effect configuration |
| fx_en_o | output | 1 | Spatial effect enable |
| vol_mono_o | output | 5 | Mono volume code |
| vol_left_o | output | 5 | Left volume code |
| vol_right_o | output | 5 | Right volume code |

## Verification
Two events can land close together: the end of one byte's acknowledge clock, which commits that byte to a register, and the start of the next byte or a bus condition. The bench sends back-to-back data bytes in one transaction and cuts bytes short with a STOP or repeated START. A behavioural model commits each byte only after the acknowledge and is compared with the outputs on every clock, so an early commit, a double commit or a partial byte that leaks through all show up as mismatches. Acknowledge levels are sampled at the wired SDA level in the middle of each ninth clock, and the outputs are compared with expected values while SCL is still high on that clock.

// File: rtl/actl_pkg.sv
package actl_pkg;
  localparam int BYTE_W  = 8;
  localparam int VOL_W   = 5;
  localparam int MODE_W  = 3;
  localparam int LEVEL_W = 2;
  localparam int CNT_W   = $clog2(BYTE_W + 1);
  // upper six bits of the device address, pin bit and write flag follow
  localparam logic [5:0] DEV_PREFIX = 6'b111110;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK_A,
    ST_DATA,
    ST_ACK_D,
    ST_SKIP
  } rx_state_e;

  typedef struct packed {
    logic [MODE_W-1:0]  mode_code;
    logic               diff_sel;
    logic               capless;
    logic               pair2_sel;
    logic               pair1_sel;
    logic [LEVEL_W-1:0] fx_level;
    logic               fx_cfg;
    logic               fx_en;
    logic [VOL_W-1:0]   vol_mono;
    logic [VOL_W-1:0]   vol_left;
    logic [VOL_W-1:0]   vol_right;
  } ctrl_regs_t;
endpackage

// File: rtl/actl_sync.sv
module actl_sync #(
  parameter int STAGES = 2,
  parameter int LINES  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LINES-1:0] raw_i,
  output logic [LINES-1:0] lvl_o,
  output logic [LINES-1:0] rise_o,
  output logic [LINES-1:0] fall_o
);
  localparam int MSB = STAGES - 1;

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] pipe_q;
    logic              prev_q;

    // idle bus level is high, so reset to 1 to avoid a false edge
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pipe_q <= '1;
        prev_q <= 1'b1;
      end else begin
        pipe_q <= {pipe_q[STAGES-2:0], raw_i[g]};
        prev_q <= pipe_q[MSB];
      end
    end

    assign lvl_o[g]  = pipe_q[MSB];
    assign rise_o[g] = pipe_q[MSB] & ~prev_q;
    assign fall_o[g] = ~pipe_q[MSB] & prev_q;
  end
endmodule

// File: rtl/actl_rx.sv
module actl_rx
  import actl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              sda_rise_i,
  input  logic              sda_fall_i,
  input  logic              addr_sel_i,
  output logic              sda_pull_o,
  output logic              wr_valid_o,
  output logic [BYTE_W-1:0] wr_byte_o
);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);

  rx_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] shreg_q;
  logic              ack_seen_q;
  logic              start_w, stop_w;
  logic [BYTE_W-1:0] dev_byte;

  assign start_w  = scl_i & sda_fall_i;
  assign stop_w   = scl_i & sda_rise_i;
  assign dev_byte = {DEV_PREFIX, addr_sel_i, 1'b0};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      shreg_q    <= '0;
      ack_seen_q <= 1'b0;
      sda_pull_o <= 1'b0;
      wr_valid_o <= 1'b0;
      wr_byte_o  <= '0;
    end else begin
      wr_valid_o <= 1'b0;
      if (start_w) begin
        state_q    <= ST_ADDR;
        cnt_q      <= '0;
        ack_seen_q <= 1'b0;
        sda_pull_o <= 1'b0;
      end else if (stop_w) begin
        state_q    <= ST_IDLE;
        cnt_q      <= '0;
        ack_seen_q <= 1'b0;
        sda_pull_o <= 1'b0;
      end else begin
        unique case (state_q)
          ST_ADDR, ST_DATA: begin
            if (scl_rise_i && cnt_q != CNT_FULL) begin
              shreg_q <= {shreg_q[BYTE_W-2:0], sda_i};
              cnt_q   <= cnt_q + 1'b1;
            end else if (scl_fall_i && cnt_q == CNT_FULL) begin
              ack_seen_q <= 1'b0;
              if (state_q == ST_DATA) begin
                state_q    <= ST_ACK_D;
                sda_pull_o <= 1'b1;
              end else if (shreg_q == dev_byte) begin
                state_q    <= ST_ACK_A;
                sda_pull_o <= 1'b1;
              end else begin
                state_q <= ST_SKIP;
              end
            end
          end
          ST_ACK_A, ST_ACK_D: begin
            if (scl_rise_i) begin
              ack_seen_q <= 1'b1;
            end else if (scl_fall_i && ack_seen_q) begin
              sda_pull_o <= 1'b0;
              cnt_q      <= '0;
              state_q    <= ST_DATA;
              if (state_q == ST_ACK_D) begin
                wr_valid_o <= 1'b1;
                wr_byte_o  <= shreg_q;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  a_r2_start_clears_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_w |=> (cnt_q == '0 && state_q == ST_ADDR));

  a_r3_ack_only_on_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ACK_A) |-> (shreg_q == dev_byte));

  a_r9_commit_after_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |-> ($past(state_q) == ST_ACK_D && !scl_i));

  a_r11_pull_steady_scl_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_i && $past(scl_i) && !stop_w && !$past(stop_w)) |-> $stable(sda_pull_o));
endmodule

// File: rtl/actl_regs.sv
module actl_regs
  import actl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  input  logic [BYTE_W-1:0] wr_byte_i,
  output ctrl_regs_t        regs_o
);
  ctrl_regs_t regs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      regs_q <= '0;
    end else if (wr_valid_i) begin
      casez (wr_byte_i[7:5])
        3'b00?: begin
          regs_q.diff_sel  <= wr_byte_i[5];
          regs_q.capless   <= wr_byte_i[3];
          regs_q.mode_code <= wr_byte_i[MODE_W-1:0];
        end
        3'b01?: begin
          regs_q.pair2_sel <= wr_byte_i[5];
          regs_q.pair1_sel <= wr_byte_i[4];
          regs_q.fx_level  <= wr_byte_i[3:2];
          regs_q.fx_cfg    <= wr_byte_i[1];
          regs_q.fx_en     <= wr_byte_i[0];
        end
        3'b100:  regs_q.vol_mono  <= wr_byte_i[VOL_W-1:0];
        3'b110:  regs_q.vol_left  <= wr_byte_i[VOL_W-1:0];
        3'b111:  regs_q.vol_right <= wr_byte_i[VOL_W-1:0];
        default: ;  // 101: reserved, dropped
      endcase
    end
  end

  assign regs_o = regs_q;

  a_r8_reserved_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && wr_byte_i[7:5] == 3'b101) |=> $stable(regs_q));

  a_r9_hold_without_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_valid_i |=> $stable(regs_q));
endmodule

// File: rtl/audio_ctl_i2c_slave.sv
module audio_ctl_i2c_slave
  import actl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               scl_i,
  input  logic               sda_i,
  input  logic               addr_sel_i,
  output logic               sda_pull_o,
  output logic [MODE_W-1:0]  mode_o,
  output logic               diff_sel_o,
  output logic               capless_o,
  output logic               pair2_sel_o,
  output logic               pair1_sel_o,
  output logic [LEVEL_W-1:0] fx_level_o,
  output logic               fx_cfg_o,
  output logic               fx_en_o,
  output logic [VOL_W-1:0]   vol_mono_o,
  output logic [VOL_W-1:0]   vol_left_o,
  output logic [VOL_W-1:0]   vol_right_o
);
  logic [1:0]        lvl, rise, fall;
  logic              wr_valid;
  logic [BYTE_W-1:0] wr_byte;
  ctrl_regs_t        regs;

  // line 1 = SCL, line 0 = SDA
  actl_sync #(.STAGES(SYNC_STAGES), .LINES(2)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .raw_i  ({scl_i, sda_i}),
    .lvl_o  (lvl),
    .rise_o (rise),
    .fall_o (fall)
  );

  actl_rx u_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (lvl[1]),
    .sda_i      (lvl[0]),
    .scl_rise_i (rise[1]),
    .scl_fall_i (fall[1]),
    .sda_rise_i (rise[0]),
    .sda_fall_i (fall[0]),
    .addr_sel_i (addr_sel_i),
    .sda_pull_o (sda_pull_o),
    .wr_valid_o (wr_valid),
    .wr_byte_o  (wr_byte)
  );

  actl_regs u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_valid_i (wr_valid),
    .wr_byte_i  (wr_byte),
    .regs_o     (regs)
  );

  assign mode_o      = regs.mode_code;
  assign diff_sel_o  = regs.diff_sel;
  assign capless_o   = regs.capless;
  assign pair2_sel_o = regs.pair2_sel;
  assign pair1_sel_o = regs.pair1_sel;
  assign fx_level_o  = regs.fx_level;
  assign fx_cfg_o    = regs.fx_cfg;
  assign fx_en_o     = regs.fx_en;
  assign vol_mono_o  = regs.vol_mono;
  assign vol_left_o  = regs.vol_left;
  assign vol_right_o = regs.vol_right;

  a_r1_no_pull_after_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> !sda_pull_o);
endmodule

// File: tb/sim_audio_ctl_i2c_slave.sv
`timescale 1ns/1ps
module sim_audio_ctl_i2c_slave;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, addr_sel = 1'b0;
  logic mask = 1'b0, done = 1'b0;
  int   checks = 0, errors = 0;

  logic       sda_pull;
  logic [2:0] mode;
  logic       diff_sel, capless, pair2, pair1, fx_cfg, fx_en;
  logic [1:0] fx_level;
  logic [4:0] vol_m, vol_l, vol_r;
  wire        sda_line = sda_m & ~sda_pull;

  // reference state
  logic [2:0] e_mode = '0;
  logic       e_diff = 0, e_capless = 0, e_p2 = 0, e_p1 = 0, e_cfg = 0, e_en = 0;
  logic [1:0] e_level = '0;
  logic [4:0] e_vm = '0, e_vl = '0, e_vr = '0;
  bit         sel_ok = 0;

  always #2.5 clk = ~clk;

  audio_ctl_i2c_slave u0 (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .addr_sel_i(addr_sel), .sda_pull_o(sda_pull), .mode_o(mode),
    .diff_sel_o(diff_sel), .capless_o(capless), .pair2_sel_o(pair2),
    .pair1_sel_o(pair1), .fx_level_o(fx_level), .fx_cfg_o(fx_cfg),
    .fx_en_o(fx_en), .vol_mono_o(vol_m), .vol_left_o(vol_l), .vol_right_o(vol_r)
  );

  function automatic logic [25:0] act_vec();
    return {mode, diff_sel, capless, pair2, pair1, fx_level, fx_cfg, fx_en, vol_m, vol_l, vol_r};
  endfunction
  function automatic logic [25:0] exp_vec();
    return {e_mode, e_diff, e_capless, e_p2, e_p1, e_level, e_cfg, e_en, e_vm, e_vl, e_vr};
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // per-clock comparison against the model (R5 R6 R7 R8 R9 R10)
  always @(posedge clk) begin
    #1.25;
    if (rst_n && !mask && !done) begin
      checks++;
      if (act_vec() !== exp_vec()) begin
        errors++;
        $display("FAIL R9 per-clock regs act=%h exp=%h", act_vec(), exp_vec());
      end
    end
  end

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic model_write(input logic [7:0] b);
    casez (b[7:5])
      3'b00?: begin e_diff = b[5]; e_capless = b[3]; e_mode = b[2:0]; end
      3'b01?: begin e_p2 = b[5]; e_p1 = b[4]; e_level = b[3:2]; e_cfg = b[1]; e_en = b[0]; end
      3'b100: e_vm = b[4:0];
      3'b110: e_vl = b[4:0];
      3'b111: e_vr = b[4:0];
      default: ;
    endcase
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wt(Q); scl_m = 1'b1; wt(Q); sda_m = 1'b0; wt(Q); scl_m = 1'b0; wt(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wt(Q); scl_m = 1'b1; wt(Q); sda_m = 1'b1; wt(Q);
  endtask

  task automatic send_bit(input bit b);
    sda_m = b; wt(Q); scl_m = 1'b1; wt(2*Q); scl_m = 1'b0; wt(Q);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) send_bit(b[i]);
  endtask

  // ninth clock: sample wired SDA mid-high, commit model after SCL falls
  task automatic ack_slot(input bit exp_ack, input bit commit, input logic [7:0] b, input string tag);
    bit acked;
    sda_m = 1'b1; wt(Q); scl_m = 1'b1; wt(Q);
    acked = !sda_line;
    chk(acked == exp_ack, tag, acked, exp_ack);
    // R9: nothing committed yet while the ninth clock is high
    chk(act_vec() === exp_vec(), "R9 no early commit", act_vec(), exp_vec());
    wt(Q);
    mask = 1'b1; scl_m = 1'b0; wt(Q);
    if (commit) model_write(b);
    mask = 1'b0;
  endtask

  task automatic send_addr(input logic [7:0] a);
    sel_ok = (a == {6'b111110, addr_sel, 1'b0});
    send_bits(a, 8);
    ack_slot(sel_ok, 1'b0, a, "R3 address ack");
  endtask

  task automatic send_data(input logic [7:0] b);
    send_bits(b, 8);
    ack_slot(sel_ok, sel_ok, b, sel_ok ? "R4 data ack" : "R3 ignored data nack");
  endtask

  initial begin
    wt(5);
    chk(act_vec() == '0 && sda_pull == 1'b0, "R1 reset in reset", act_vec(), 0);
    rst_n = 1'b1; wt(5);
    chk(act_vec() == '0, "R1 reset outputs", act_vec(), 0);
    chk(sda_pull == 1'b0, "R1 sda released", sda_pull, 0);

    // mode register, pin low
    bus_start(); send_addr(8'hF8); send_data(8'h2D); bus_stop(); wt(Q);
    chk(mode == 3'd5, "R5 mode code", mode, 5);
    chk(diff_sel == 1 && capless == 1, "R5 diff/capless", {diff_sel, capless}, 3);

    // mode byte with bit 4 set: bit 4 not stored
    bus_start(); send_addr(8'hF8); send_data(8'h11); bus_stop(); wt(Q);
    chk(mode == 3'd1 && diff_sel == 0 && capless == 0, "R5 bit4 dropped", {mode, diff_sel, capless}, 4);
    bus_start(); send_addr(8'hF8); send_data(8'h2D); bus_stop(); wt(Q);

    // effect register
    bus_start(); send_addr(8'hF8); send_data(8'h7B); bus_stop(); wt(Q);
    chk({pair2, pair1, fx_level, fx_cfg, fx_en} == 6'b111011, "R6 effect fields",
        {pair2, pair1, fx_level, fx_cfg, fx_en}, 6'b111011);

    // three volumes in one transaction
    bus_start(); send_addr(8'hF8);
    send_data(8'h95); send_data(8'hD3); send_data(8'hFF); bus_stop(); wt(Q);
    chk(vol_m == 5'h15, "R7 mono vol", vol_m, 5'h15);
    chk(vol_l == 5'h13, "R7 left vol", vol_l, 5'h13);
    chk(vol_r == 5'h1F, "R10 last byte of burst", vol_r, 5'h1F);

    // reserved selector
    bus_start(); send_addr(8'hF8); send_data(8'hAA); bus_stop(); wt(Q);
    chk(act_vec() == exp_vec() && mode == 3'd5 && vol_m == 5'h15, "R8 reserved no change", act_vec(), exp_vec());

    // wrong address and read flag
    bus_start(); send_addr(8'hFA); send_data(8'h00); bus_stop(); wt(Q);
    chk(mode == 3'd5, "R3 mismatch ignored", mode, 5);
    bus_start(); send_addr(8'hF9); send_data(8'h80); bus_stop(); wt(Q);
    chk(vol_m == 5'h15, "R3 read flag ignored", vol_m, 5'h15);

    // pin high
    addr_sel = 1'b1; wt(Q);
    bus_start(); send_addr(8'hF8); send_data(8'h07); bus_stop(); wt(Q);
    chk(mode == 3'd5, "R3 old address rejected", mode, 5);
    bus_start(); send_addr(8'hFA); send_data(8'h03); bus_stop(); wt(Q);
    chk(mode == 3'd3 && diff_sel == 0, "R3 pin-high address", mode, 3);

    // STOP mid-byte
    bus_start(); send_addr(8'hFA); send_bits(8'h06, 4); bus_stop(); wt(Q);
    chk(mode == 3'd3, "R9 stop discards partial", mode, 3);

    // repeated START mid-byte, then a fresh write
    bus_start(); send_addr(8'hFA); send_bits(8'h40, 5);
    bus_start(); send_addr(8'hFA); send_data(8'h9F); bus_stop(); wt(Q);
    chk(vol_m == 5'h1F, "R2 repeated start write", vol_m, 5'h1F);
    chk({pair2, pair1, fx_level, fx_cfg, fx_en} == 6'b111011, "R9 restart discards partial",
        {pair2, pair1, fx_level, fx_cfg, fx_en}, 6'b111011);

    // mismatch, then repeated START with a good address
    bus_start(); send_addr(8'hF8); bus_start(); send_addr(8'hFA);
    send_data(8'hC0); send_data(8'h06); bus_stop(); wt(Q);
    chk(vol_l == 5'h00 && mode == 3'd6, "R10 burst after restart", {vol_l, mode}, 6);
    chk(sda_pull == 1'b0, "R11 released when idle", sda_pull, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog act=0 exp=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule